// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Configuration Unlock

This block is a watchdog timer on a simple register bus. Software restarts it by writing a refresh key to the counter register. If the count of prescaled ticks reaches the timeout value, the block first raises an interrupt flag. It then raises a reset request. In window mode, a refresh that arrives while the count is still below the window value is treated as a fault.

The configuration is protected by a keyed unlock. Software writes an unlock key to the counter register. This opens a configuration window that lasts a fixed number of bus clocks. Inside that window, the control, timeout and window registers each take a single write. A mode bit in the control register selects the key format: either one 32-bit key word, or a pair of 16-bit key words written one after the other. An update-enable bit decides whether the block may be unlocked again after its first configuration.

The `tick` input is the counting clock enable, supplied by an external source. Any other value written to the counter register is treated as a fault, and so is a broken 16-bit key pair. A fault raises the reset request at once. The reset request stays high until the block itself is reset.

Top module: `wdg_top`

## Requirements
- R1: Writing 0xD928C520 to the counter register (address 1) unlocks when the key-width bit (control bit 4) is 1. When that bit is 0, the two 16-bit writes 0xC520 and then 0xD928 unlock; the upper 16 bits are ignored in this mode.
- R2: The unlocked status bit (control bit 12) reads 1 starting in the cycle after an accepted unlock, and reads 1 for as long as the window is open.
- R3: The window accepts configuration writes on exactly the 128 clock edges that follow the unlock edge. A write to address 0, 2 or 3 at any other time leaves the register unchanged.
- R4: Within one window, only the first write to each of the control (address 0), timeout (address 2) and window (address 3) registers takes effect.
- R5: Once a window has closed with the update-enable bit (control bit 3) at 0, unlock keys are ignored: no window opens and no reset request is raised.
- R6: The reconfiguration-done bit (control bit 13) reads 0 while a window is open. It reads 1 after the window closes and after reset.
- R7: A refresh writes 0xB480A602 in 32-bit mode, or 0xA602 and then 0xB480 in 16-bit mode. A refresh clears the counter and the prescaler. When window mode (control bit 2) is 1 and the counter is below the window value, the refresh raises the reset request instead.
- R8: When the count reaches the timeout with interrupt enable (control bit 1) at 0, the reset request rises on the same edge. When interrupt enable is 1, the flag (control bit 14) and `irq` rise on that edge, and the reset request follows 128 clocks later.
- R9: After reset, the control register reads 0x00002038 (key-width 1, update-enable 1, run-in-wait 1, done 1), the timeout reads 0xFFFF, the window value reads 0, and the reset request and `irq` are 0.
- R10: A counter-register write that is neither a valid key nor a valid key half raises the reset request. A 16-bit key pair written out of order also raises it. The reset request stays high until reset.
- R11: Writing 1 to control bit 14 clears the flag at any time, whether the registers are locked or not. A write to bit 14 while locked changes no other field.
- R12: The counter advances once per `tick` while enable (control bit 0) is 1 and no window is open. With prescale (control bit 10) at 1, it advances once per 256 ticks. While a window is open, the counter is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counting clock enable |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 counter, 2 timeout, 3 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt: flag AND interrupt enable |
| rst_req | output | 1 | Sticky reset request |

## Verification
Register writes, the unlock status, the done bit and the counter clear all settle on the clock edge that samples the write. The bench therefore reads them back at the next falling edge. A fault raises `rst_req` on that same edge; with the interrupt enabled, a timeout raises it 128 edges later. The bench measures that gap from the flag's rise, counting in clock periods. Window edges are hit on purpose: a write lands 128 edges after the unlock edge, and another lands 129 edges after it. A behavioural model is stepped on every rising edge, and its `rst_req` and `irq` are compared 1 ns later.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [31:0] UNLK_KEY32 = 32'hD928C520;
  localparam logic [31:0] RFSH_KEY32 = 32'hB480A602;
  localparam logic [15:0] UNLK_LO = 16'hC520;
  localparam logic [15:0] UNLK_HI = 16'hD928;
  localparam logic [15:0] RFSH_LO = 16'hA602;
  localparam logic [15:0] RFSH_HI = 16'hB480;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_TOV  = 2'd2;
  localparam logic [1:0] A_WIN  = 2'd3;

  localparam int B_FLAG = 14;

  typedef enum logic [1:0] {EV_NONE, EV_UNLOCK, EV_REFRESH, EV_BAD} key_ev_e;
  typedef enum logic [1:0] {PH_IDLE, PH_UNLK, PH_RFSH} key_ph_e;

  typedef struct packed {
    logic       pres;
    logic [1:0] src;
    logic       dbg;
    logic       stop;
    logic       run_wait;
    logic       key32;
    logic       upd;
    logic       wm;
    logic       ie;
    logic       en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 11'h038;

  function automatic logic refresh_too_early(logic wm, logic [15:0] cnt, logic [15:0] win);
    return wm && (cnt < win);
  endfunction

  function automatic logic cnt_hits(logic [15:0] cnt, logic [15:0] tov);
    return ({1'b0, cnt} + 17'd1) == {1'b0, tov};
  endfunction
endpackage

// File: rtl/wdg_key_dec.sv
module wdg_key_dec
  import wdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stb,
  input  logic        key32,
  input  logic [31:0] data,
  output key_ev_e     ev
);
  key_ph_e ph, ph_n;

  always_comb begin
    ev   = EV_NONE;
    ph_n = ph;
    if (stb) begin
      if (key32) begin
        ph_n = PH_IDLE;
        if (data == UNLK_KEY32)      ev = EV_UNLOCK;
        else if (data == RFSH_KEY32) ev = EV_REFRESH;
        else                         ev = EV_BAD;
      end else begin
        case (ph)
          PH_IDLE: begin
            if (data[15:0] == UNLK_LO)      ph_n = PH_UNLK;
            else if (data[15:0] == RFSH_LO) ph_n = PH_RFSH;
            else                            ev = EV_BAD;
          end
          PH_UNLK: begin
            ph_n = PH_IDLE;
            ev   = (data[15:0] == UNLK_HI) ? EV_UNLOCK : EV_BAD;
          end
          PH_RFSH: begin
            ph_n = PH_IDLE;
            ev   = (data[15:0] == RFSH_HI) ? EV_REFRESH : EV_BAD;
          end
          default: ph_n = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_IDLE;
    else        ph <= ph_n;
  end
endmodule

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs
  import wdg_pkg::*;
#(
  parameter int CFG_CLKS = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        unlock_req,
  input  logic        wr_ctrl,
  input  logic        wr_tov,
  input  logic        wr_win,
  input  logic [15:0] wdata,
  output ctrl_t       ctrl,
  output logic [15:0] tov,
  output logic [15:0] win,
  output logic        unlocked,
  output logic        done,
  output logic        unlock_go,
  output logic        frozen,
  output logic        tov_used
);
  localparam int CFG_W = $clog2(CFG_CLKS + 1);

  logic [CFG_W-1:0] left;
  logic ctrl_used, win_used, cfg_once;
  logic acc_ctrl, acc_tov, acc_win;

  assign unlocked  = (left != '0);
  assign frozen    = cfg_once && !ctrl.upd;
  assign unlock_go = unlock_req && !frozen;
  assign acc_ctrl  = wr_ctrl && unlocked && !ctrl_used;
  assign acc_tov   = wr_tov  && unlocked && !tov_used;
  assign acc_win   = wr_win  && unlocked && !win_used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left      <= '0;
      done      <= 1'b1;
      cfg_once  <= 1'b0;
      ctrl_used <= 1'b0;
      tov_used  <= 1'b0;
      win_used  <= 1'b0;
      ctrl      <= CTRL_RST;
      tov       <= 16'hFFFF;
      win       <= 16'h0000;
    end else begin
      if (unlock_go) begin
        left      <= CFG_W'(CFG_CLKS);
        done      <= 1'b0;
        ctrl_used <= 1'b0;
        tov_used  <= 1'b0;
        win_used  <= 1'b0;
      end else if (unlocked) begin
        left <= left - 1'b1;
        if (left == CFG_W'(1)) begin
          done     <= 1'b1;
          cfg_once <= 1'b1;
        end
      end
      if (acc_ctrl) begin
        ctrl      <= ctrl_t'(wdata[10:0]);
        ctrl_used <= 1'b1;
      end
      if (acc_tov) begin
        tov      <= wdata;
        tov_used <= 1'b1;
      end
      if (acc_win) begin
        win      <= wdata;
        win_used <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdg_count_core.sv
module wdg_count_core
  import wdg_pkg::*;
#(
  parameter int PRE_SHIFT = 8,
  parameter int IRQ_DLY   = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        en,
  input  logic        ie,
  input  logic        pres,
  input  logic        hold,
  input  logic        refresh_go,
  input  logic        fault,
  input  logic        clr_flag,
  input  logic [15:0] tov,
  output logic [15:0] cnt,
  output logic        flag,
  output logic        rst_req,
  output logic        expire,
  output logic        delay_end
);
  localparam int DLY_W = $clog2(IRQ_DLY + 1);

  logic run, cnt_tick, armed;
  logic [DLY_W-1:0] dly;

  assign run = en && !hold;

  generate
    if (PRE_SHIFT > 0) begin : g_pre
      logic [PRE_SHIFT-1:0] pre;
      assign cnt_tick = tick && (!pres || (&pre));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pre <= '0;
        else if (hold || refresh_go) pre <= '0;
        else if (run && tick && pres) pre <= pre + 1'b1;
      end
    end else begin : g_nopre
      assign cnt_tick = tick;
    end
  endgenerate

  assign expire    = run && cnt_tick && cnt_hits(cnt, tov);
  assign delay_end = armed && (dly == DLY_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      flag    <= 1'b0;
      armed   <= 1'b0;
      dly     <= '0;
      rst_req <= 1'b0;
    end else begin
      if (hold || refresh_go)
        cnt <= '0;
      else if (run && cnt_tick && (cnt != tov))
        cnt <= cnt + 1'b1;

      if (expire && ie)  flag <= 1'b1;
      else if (clr_flag) flag <= 1'b0;

      if (expire && ie) begin
        armed <= 1'b1;
        dly   <= DLY_W'(IRQ_DLY);
      end else if (armed) begin
        dly <= dly - 1'b1;
        if (delay_end) armed <= 1'b0;
      end

      if (fault || (expire && !ie) || delay_end)
        rst_req <= 1'b1;
    end
  end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int CFG_CLKS  = 128,
  parameter int IRQ_DLY   = 128,
  parameter int PRE_SHIFT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        rst_req
);
  ctrl_t       ctrl;
  logic [15:0] tov, win, cnt;
  logic        unlocked, done, unlock_go, frozen, tov_used;
  logic        flag, expire, delay_end;
  key_ev_e     ev;

  logic wr_cnt, wr_ctrl, wr_tov, wr_win;
  logic unlock_req, refresh_req, early, refresh_go, fault, clr_flag;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_cnt  = bus_wr && (bus_addr == A_CNT);
  assign wr_tov  = bus_wr && (bus_addr == A_TOV);
  assign wr_win  = bus_wr && (bus_addr == A_WIN);

  wdg_key_dec u_key (
    .clk(clk), .rst_n(rst_n), .stb(wr_cnt), .key32(ctrl.key32),
    .data(bus_wdata), .ev(ev)
  );

  assign unlock_req  = (ev == EV_UNLOCK);
  assign refresh_req = (ev == EV_REFRESH);
  assign early       = refresh_req && refresh_too_early(ctrl.wm, cnt, win);
  assign refresh_go  = refresh_req && !early;
  assign fault       = (ev == EV_BAD) || early;
  assign clr_flag    = wr_ctrl && bus_wdata[B_FLAG];

  wdg_cfg_regs #(.CFG_CLKS(CFG_CLKS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .unlock_req(unlock_req),
    .wr_ctrl(wr_ctrl), .wr_tov(wr_tov), .wr_win(wr_win),
    .wdata(bus_wdata[15:0]), .ctrl(ctrl), .tov(tov), .win(win),
    .unlocked(unlocked), .done(done), .unlock_go(unlock_go),
    .frozen(frozen), .tov_used(tov_used)
  );

  wdg_count_core #(.PRE_SHIFT(PRE_SHIFT), .IRQ_DLY(IRQ_DLY)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl.en), .ie(ctrl.ie),
    .pres(ctrl.pres), .hold(unlocked), .refresh_go(refresh_go),
    .fault(fault), .clr_flag(clr_flag), .tov(tov), .cnt(cnt),
    .flag(flag), .rst_req(rst_req), .expire(expire), .delay_end(delay_end)
  );

  assign irq = flag && ctrl.ie;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {17'd0, flag, done, unlocked, 1'b0, ctrl};
      A_CNT:   bus_rdata = {16'd0, cnt};
      A_TOV:   bus_rdata = {16'd0, tov};
      default: bus_rdata = {16'd0, win};
    endcase
  end
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        unlock_go,
  input logic        unlock_req,
  input logic        frozen,
  input logic        unlocked,
  input logic        done,
  input logic        wr_tov,
  input logic [15:0] tov,
  input logic        tov_used,
  input logic        expire,
  input logic        ie,
  input logic        fault,
  input logic        flag,
  input logic        rst_req
);
  // R2
  unlock_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_go |=> unlocked);
  // R3
  locked_tov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_tov) |=> $stable(tov));
  // R4
  tov_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && tov_used && wr_tov) |=> $stable(tov));
  // R5
  frozen_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !unlocked && unlock_req) |=> !unlocked);
  // R6
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(unlocked && done));
  // R8
  direct_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ie) |=> rst_req);
  // R8
  flag_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ie) |=> flag);
  // R10
  fault_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> rst_req);
  // R10
  reset_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
endmodule

bind wdg_top wdg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .unlock_go(unlock_go), .unlock_req(unlock_req),
  .frozen(frozen), .unlocked(unlocked), .done(done), .wr_tov(wr_tov),
  .tov(tov), .tov_used(tov_used), .expire(expire), .ie(ctrl.ie),
  .fault(fault), .flag(flag), .rst_req(rst_req)
);

// File: tb/wdg_top_tb.sv
`timescale 1ns/1ps
module wdg_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, rst_req;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wdg_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  // behavioural reference model
  int m_cnt, m_pre, m_tov, m_win, m_left, m_ph, m_dly;
  bit m_en, m_ie, m_wm, m_upd, m_k32, m_pres;
  bit m_wctl, m_wtov, m_wwin, m_once, m_done, m_flag, m_arm, m_rst;

  task automatic m_reset();
    m_cnt = 0; m_pre = 0; m_tov = 16'hFFFF; m_win = 0; m_left = 0; m_ph = 0; m_dly = 0;
    m_en = 0; m_ie = 0; m_wm = 0; m_upd = 1; m_k32 = 1; m_pres = 0;
    m_wctl = 0; m_wtov = 0; m_wwin = 0; m_once = 0; m_done = 1;
    m_flag = 0; m_arm = 0; m_rst = 0;
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int ev, nph;
      bit hold, early, fault, ulk, run, ctick, exp_ev, hit;
      logic [31:0] d;
      d = bus_wdata; ev = 0; nph = m_ph;
      if (bus_wr && bus_addr == 2'd1) begin
        if (m_k32) begin
          nph = 0;
          ev = (d == 32'hD928C520) ? 1 : (d == 32'hB480A602) ? 2 : 3;
        end else if (m_ph == 0) begin
          if (d[15:0] == 16'hC520) nph = 1;
          else if (d[15:0] == 16'hA602) nph = 2;
          else ev = 3;
        end else begin
          ev = (m_ph == 1) ? ((d[15:0] == 16'hD928) ? 1 : 3)
                           : ((d[15:0] == 16'hB480) ? 2 : 3);
          nph = 0;
        end
      end
      m_ph = nph;
      hold  = (m_left > 0);
      early = (ev == 2) && m_wm && (m_cnt < m_win);
      fault = (ev == 3) || early;
      ulk   = (ev == 1) && (m_upd || !m_once);
      run   = m_en && !hold;
      ctick = tick && (!m_pres || m_pre == 255);
      exp_ev = run && ctick && (m_cnt + 1 == m_tov);
      hit = m_arm && (m_dly == 1);
      if (fault || (exp_ev && !m_ie) || hit) m_rst = 1;
      if (exp_ev && m_ie) begin m_arm = 1; m_dly = 128; end
      else if (m_arm) begin m_dly--; if (m_dly == 0) m_arm = 0; end
      if (exp_ev && m_ie) m_flag = 1;
      else if (bus_wr && bus_addr == 2'd0 && d[14]) m_flag = 0;
      if (hold || ((ev == 2) && !early)) begin m_cnt = 0; m_pre = 0; end
      else if (run && tick) begin
        if (m_pres) m_pre = (m_pre + 1) % 256;
        if (ctick && m_cnt != m_tov) m_cnt++;
      end
      if (hold && bus_wr) begin
        if (bus_addr == 2'd0 && !m_wctl) begin
          m_en = d[0]; m_ie = d[1]; m_wm = d[2]; m_upd = d[3]; m_k32 = d[4];
          m_pres = d[10]; m_wctl = 1;
        end
        if (bus_addr == 2'd2 && !m_wtov) begin m_tov = d[15:0]; m_wtov = 1; end
        if (bus_addr == 2'd3 && !m_wwin) begin m_win = d[15:0]; m_wwin = 1; end
      end
      if (ulk) begin m_left = 128; m_wctl = 0; m_wtov = 0; m_wwin = 0; m_done = 0; end
      else if (m_left > 0) begin
        if (m_left == 1) begin m_done = 1; m_once = 1; end
        m_left--;
      end
    end
    #1;
    if (rst_n && !finished) begin
      chk("R8/R10 model rst_req", {31'd0, rst_req}, {31'd0, m_rst});
      chk("R8/R11 model irq", {31'd0, irq}, {31'd0, m_flag && m_ie});
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(logic [15:0] t, logic [15:0] w, logic [31:0] c);
    wr(2'd1, 32'hD928C520);
    wr(2'd2, {16'd0, t});
    wr(2'd3, {16'd0, w});
    wr(2'd0, c);
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] r;
    realtime t1, t2;
    int n;
    do_reset();
    // R9 reset values
    rd(2'd0, r); chk("R9 ctrl reset", r, 32'h00002038);
    rd(2'd2, r); chk("R9 timeout reset", r, 32'h0000FFFF);
    rd(2'd3, r); chk("R9 window reset", r, 32'h0);
    chk("R9 rst_req reset", {31'd0, rst_req}, 32'd0);
    // R3 locked write ignored
    wr(2'd2, 32'd50);
    rd(2'd2, r); chk("R3 locked timeout write", r, 32'h0000FFFF);
    // R1/R2 32-bit unlock
    wr(2'd1, 32'hD928C520);
    rd(2'd0, r);
    chk("R2 unlocked bit", {31'd0, r[12]}, 32'd1);
    chk("R6 done low in window", {31'd0, r[13]}, 32'd0);
    // R4 write once
    wr(2'd2, 32'd40); wr(2'd2, 32'd99);
    rd(2'd2, r); chk("R4 timeout once", r, 32'd40);
    wr(2'd0, 32'h19); wr(2'd0, 32'h0);
    rd(2'd0, r); chk("R4 ctrl once", {31'd0, r[0]}, 32'd1);
    repeat (130) @(posedge clk);
    rd(2'd0, r); chk("R6 done after close", {30'd0, r[13:12]}, 32'd2);
    // R12 counting
    repeat (20) @(posedge clk);
    rd(2'd1, r); chk("R12 counter runs", r, m_cnt);
    // R7 refresh clears
    wr(2'd1, 32'hB480A602);
    rd(2'd1, r); chk("R7 refresh clears counter", r, 32'd0);
    // R8 direct reset
    repeat (45) @(posedge clk);
    #1 chk("R8 reset without interrupt", {31'd0, rst_req}, 32'd1);

    // R3 window boundary
    do_reset();
    wr(2'd1, 32'hD928C520);
    repeat (127) @(posedge clk);
    wr(2'd3, 32'd7);
    rd(2'd3, r); chk("R3 write on last window edge", r, 32'd7);
    wr(2'd1, 32'hD928C520);
    repeat (128) @(posedge clk);
    wr(2'd3, 32'd9);
    rd(2'd3, r); chk("R3 write after window", r, 32'd7);

    // R8 interrupt path, R11 flag clear
    do_reset();
    cfg(16'd30, 16'd0, 32'h1B);
    n = 0;
    while (!irq && n < 600) begin @(negedge clk); n++; end
    t1 = $realtime;
    chk("R8 irq raised", {31'd0, irq}, 32'd1);
    chk("R8 no reset yet", {31'd0, rst_req}, 32'd0);
    rd(2'd0, r); chk("R8 flag bit", {31'd0, r[14]}, 32'd1);
    wr(2'd0, 32'h4000);
    chk("R11 flag cleared", {31'd0, irq}, 32'd0);
    rd(2'd0, r); chk("R11 ctrl kept", {21'd0, r[10:0]}, 32'h1B);
    n = 0;
    while (!rst_req && n < 300) begin @(negedge clk); n++; end
    t2 = $realtime;
    chk("R8 delayed reset gap", int'((t2 - t1) / 5.0), 32'd128);

    // R7 early refresh in 16-bit window mode
    do_reset();
    cfg(16'd300, 16'd100, 32'h0D);
    repeat (130) @(posedge clk);
    wr(2'd1, 32'hA602); wr(2'd1, 32'hB480);
    chk("R7 early refresh faults", {31'd0, rst_req}, 32'd1);

    // R7 valid refresh, R1 16-bit unlock, R10 out of order
    do_reset();
    cfg(16'd300, 16'd100, 32'h0D);
    repeat (240) @(posedge clk);
    wr(2'd1, 32'hFFFFA602); wr(2'd1, 32'h0000B480);
    rd(2'd1, r); chk("R7 window refresh clears", r, 32'd0);
    chk("R7 no fault on valid refresh", {31'd0, rst_req}, 32'd0);
    wr(2'd1, 32'hC520); wr(2'd1, 32'hD928);
    rd(2'd0, r); chk("R1 16-bit unlock", {31'd0, r[12]}, 32'd1);
    wr(2'd1, 32'hD928);
    chk("R10 out-of-order key", {31'd0, rst_req}, 32'd1);

    // R10 bad 32-bit key
    do_reset();
    wr(2'd1, 32'h12345678);
    chk("R10 bad key", {31'd0, rst_req}, 32'd1);

    // R5 freeze
    do_reset();
    wr(2'd1, 32'hD928C520);
    wr(2'd0, 32'h10);
    repeat (130) @(posedge clk);
    wr(2'd1, 32'hD928C520);
    rd(2'd0, r); chk("R5 frozen unlock ignored", {31'd0, r[12]}, 32'd0);
    chk("R5 no fault on frozen key", {31'd0, rst_req}, 32'd0);
    wr(2'd2, 32'd5);
    rd(2'd2, r); chk("R5 timeout unchanged", r, 32'h0000FFFF);

    // R12 prescaler and hold
    do_reset();
    cfg(16'd3, 16'd0, 32'h419);
    rd(2'd1, r); chk("R12 held in window", r, 32'd0);
    repeat (700) @(posedge clk);
    rd(2'd1, r); chk("R12 prescaled count", r, m_cnt);
    repeat (300) @(posedge clk);
    #1 chk("R12 prescaled expiry", {31'd0, rst_req}, 32'd1);
    summary();
  end
endmodule